// File: doc/BRIEF.md
# Chip-Select Address Window Decoder

This block maps each processor address onto at most one of eight external device regions. Every region has its own configuration word with three fields: a 6-bit window base, a 4-bit size mask and an enable flag. The base is matched against address bits 29:24. The mask picks which of the low four window bits take part in that match. A region sized by the mask is 16 MB at its smallest and 128 MB at its largest legal thermometer setting. With an extra strap input asserted, the all-zero mask gives a 256 MB region.

The decode path is purely combinational. For each address it drives one active-high select line, a hit flag and the offset inside the chosen region. The offset wraps modulo the region size, so a device repeats through its whole window. If two enabled regions claim the same address, the lower-numbered one wins and an overlap flag is raised.

A simple register port writes and reads the configuration words. After reset, every region has the smallest size and only region 0 is enabled.

Top module: `csw_decoder`

## Requirements
- R1: After reset, the word of region 0 reads 0x00000F40 and the words of regions 1 to 7 read 0x00000F00: mask 0xF, base 0, and enabled only for region 0.
- R2: A write to a region's configuration address stores the write data ANDed with 0x00000F7F. Fields: bits 11:8 are the mask, bit 6 is the enable flag and bits 5:0 are the base. Writes to any other register address change no configuration word.
- R3: With default parameters, region i has its configuration word at register byte address 0x78 + 0x30*i. Reads of any address that is not a configuration address return zero.
- R4: A region whose enable flag (bit 6) is clear never matches an address.
- R5: Legal masks are 0x8, 0xC, 0xE and 0xF. A region holding any other nonzero mask never matches.
- R6: Mask 0x0 is legal, and selects a 256 MB region, only while `allow_full` is high. Otherwise it disables the region.
- R7: An enabled region with a legal mask matches when address bits 29:28 equal base bits 5:4, and when each address bit 24+k equals base bit k wherever mask bit k is 1. Address bits 31:30 are ignored.
- R8: On a hit, `offset` equals address bits 27:0, except that each bit 24+k is cleared where mask bit k is 1. This is the address ANDed with (region size - 1).
- R9: When several regions match, only the lowest-numbered one is asserted on `cs_sel`, where bit i is region i. `cs_sel` never has more than one bit set.
- R10: `overlap` is high exactly when two or more regions match the current address.
- R11: When no region matches, `hit` is low, and both `cs_sel` and `offset` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset of the configuration words |
| allow_full | input | 1 | Strap that makes the all-zero mask legal (256 MB region) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| addr | input | 32 | Processor address to decode |
| cs_sel | output | 8 | One-hot select, bit i for region i |
| hit | output | 1 | Some region matched |
| overlap | output | 1 | Two or more regions matched |
| offset | output | 28 | Address offset within the selected region |

## Verification
The bench builds the decoder with its default parameters. These are eight regions, banks 0x30 apart starting at 0x60, and a four-bit mask above bit 24, so the register map and the full 6-bit window compare are exercised as shipped.

Random configurations draw every one of the sixteen mask codes, with the strap toggled, so each legal and illegal encoding gets exercised. Random addresses are steered into configured windows with random values in the unmasked bit positions. This brings the offset wrap, the priority between overlapping enabled regions and the ignored top address bits within reach of a few hundred vectors.

// File: rtl/csw_pkg.sv
package csw_pkg;

   // Window geometry: the mask covers address bits WIN_LSB+MASK_W-1:WIN_LSB,
   // and the base covers address bits WIN_LSB+BASE_W-1:WIN_LSB.
   localparam int WIN_LSB = 24;
   localparam int MASK_W  = 4;
   localparam int BASE_W  = 6;
   localparam int OFS_W   = WIN_LSB + MASK_W;
   localparam int CMP_HI  = WIN_LSB + BASE_W - 1;

   // Positions of the fields inside the configuration word
   localparam int F_BASE_LSB  = 0;
   localparam int F_VALID_BIT = 6;
   localparam int F_MASK_LSB  = 8;
   localparam logic [31:0] CFG_KEEP = 32'h0000_0F7F;

   typedef struct packed {
      logic [MASK_W-1:0] mask;
      logic              valid;
      logic [BASE_W-1:0] base;
   } cs_cfg_t;

   // Legal masks are a run of ones starting at the top bit.
   // Zero is legal only when the strap allows the largest region.
   function automatic logic mask_legal(logic [MASK_W-1:0] m, logic allow_full);
      logic [MASK_W-1:0] inv;
      inv = ~m;
      if (m == '0) return allow_full;
      return ((inv & (inv + 1'b1)) == '0);
   endfunction

   function automatic logic [31:0] cfg_to_word(cs_cfg_t c);
      logic [31:0] w;
      w = '0;
      w[F_MASK_LSB +: MASK_W] = c.mask;
      w[F_VALID_BIT]          = c.valid;
      w[F_BASE_LSB +: BASE_W] = c.base;
      return w;
   endfunction

endpackage

// File: rtl/csw_region.sv
module csw_region
   import csw_pkg::*;
#(
   parameter int IDX      = 0,
   parameter int RA_W     = 10,
   parameter int CFG_ADDR = 32'h78,
   parameter int ADDR_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              allow_full,
   input  logic              reg_we,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic [ADDR_W-1:0] addr,
   output logic              cfg_hit,
   output logic [31:0]       cfg_word,
   output logic              match,
   output logic [OFS_W-1:0]  offset
);

   cs_cfg_t cfg_q;
   cs_cfg_t cfg_d;
   logic    win_eq;
   logic    unused_wdata;
   logic    unused_addr;

   assign cfg_hit = (reg_addr == RA_W'(CFG_ADDR));

   always_comb begin
      cfg_d.mask  = reg_wdata[F_MASK_LSB +: MASK_W];
      cfg_d.valid = reg_wdata[F_VALID_BIT];
      cfg_d.base  = reg_wdata[F_BASE_LSB +: BASE_W];
   end

   assign unused_wdata = ^{reg_wdata[31:F_MASK_LSB+MASK_W], reg_wdata[7]};
   assign unused_addr  = ^addr[ADDR_W-1:CMP_HI+1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q.mask  <= '1;
         cfg_q.valid <= 1'(IDX == 0);
         cfg_q.base  <= '0;
      end else if (reg_we && cfg_hit) begin
         cfg_q <= cfg_d;
      end
   end

   assign cfg_word = cfg_to_word(cfg_q);

   // Upper base bits always compare; lower ones only where the mask is set.
   assign win_eq = (((addr[CMP_HI:WIN_LSB] ^ cfg_q.base)
                     & {{(BASE_W-MASK_W){1'b1}}, cfg_q.mask}) == '0);

   assign match  = cfg_q.valid && mask_legal(cfg_q.mask, allow_full) && win_eq;
   assign offset = {addr[OFS_W-1:WIN_LSB] & ~cfg_q.mask, addr[WIN_LSB-1:0]};

   a_r2_hold_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && cfg_hit) |=> $stable(cfg_q));

   a_r2_keep_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && cfg_hit) |=> (cfg_word == ($past(reg_wdata) & CFG_KEEP)));

   a_r4_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q.valid |-> !match);

   a_r5_legal_mask: assert property (@(posedge clk) disable iff (!rst_n)
      match |-> (cfg_q.mask inside {4'h8, 4'hC, 4'hE, 4'hF}
                 || (cfg_q.mask == 4'h0 && allow_full)));

endmodule

// File: rtl/csw_prio.sv
module csw_prio #(
   parameter int N     = 8,
   parameter int OFS_W = 28
) (
   input  logic [N-1:0]            match_vec,
   input  logic [N-1:0][OFS_W-1:0] ofs_vec,
   output logic [N-1:0]            cs_sel,
   output logic                    hit,
   output logic                    overlap,
   output logic [OFS_W-1:0]        offset
);

   localparam int CNT_W = $clog2(N + 1);

   logic [CNT_W-1:0] n_match;

   always_comb begin
      cs_sel  = '0;
      offset  = '0;
      n_match = '0;
      // Walk downward so the lowest matching region is written last.
      for (int i = N - 1; i >= 0; i--) begin
         if (match_vec[i]) begin
            cs_sel  = '0;
            cs_sel[i] = 1'b1;
            offset  = ofs_vec[i];
            n_match = n_match + 1'b1;
         end
      end
   end

   assign hit     = |match_vec;
   assign overlap = (n_match > CNT_W'(1));

endmodule

// File: rtl/csw_decoder.sv
module csw_decoder
   import csw_pkg::*;
#(
   parameter int N_CS        = 8,
   parameter int ADDR_W      = 32,
   parameter int RA_W        = 10,
   parameter int BANK_BASE   = 32'h60,
   parameter int BANK_STRIDE = 32'h30,
   parameter int CFG_OFS     = 32'h18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              allow_full,
   input  logic              reg_we,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [ADDR_W-1:0] addr,
   output logic [N_CS-1:0]   cs_sel,
   output logic              hit,
   output logic              overlap,
   output logic [OFS_W-1:0]  offset
);

   localparam int LAST_CFG = BANK_BASE + (N_CS - 1) * BANK_STRIDE + CFG_OFS;

   if (N_CS < 1 || N_CS > 8) begin : g_bad_count
      $error("csw_decoder: N_CS must lie in 1..8");
   end
   if (ADDR_W < CMP_HI + 1) begin : g_bad_addr
      $error("csw_decoder: ADDR_W too narrow for the window compare");
   end
   if (CFG_OFS + 4 > BANK_STRIDE) begin : g_bad_stride
      $error("csw_decoder: configuration word falls outside its bank");
   end
   if (LAST_CFG >= (1 << RA_W)) begin : g_bad_ra
      $error("csw_decoder: register address space too small");
   end

   logic [N_CS-1:0]            match_vec;
   logic [N_CS-1:0]            cfg_hit;
   logic [N_CS-1:0][31:0]      cfg_word;
   logic [N_CS-1:0][OFS_W-1:0] ofs_vec;

   for (genvar g = 0; g < N_CS; g++) begin : g_region
      csw_region #(
         .IDX      (g),
         .RA_W     (RA_W),
         .CFG_ADDR (BANK_BASE + g * BANK_STRIDE + CFG_OFS),
         .ADDR_W   (ADDR_W)
      ) u_region (
         .clk        (clk),
         .rst_n      (rst_n),
         .allow_full (allow_full),
         .reg_we     (reg_we),
         .reg_addr   (reg_addr),
         .reg_wdata  (reg_wdata),
         .addr       (addr),
         .cfg_hit    (cfg_hit[g]),
         .cfg_word   (cfg_word[g]),
         .match      (match_vec[g]),
         .offset     (ofs_vec[g])
      );
   end

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < N_CS; i++) begin
         if (cfg_hit[i]) reg_rdata = reg_rdata | cfg_word[i];
      end
   end

   csw_prio #(
      .N     (N_CS),
      .OFS_W (OFS_W)
   ) u_prio (
      .match_vec (match_vec),
      .ofs_vec   (ofs_vec),
      .cs_sel    (cs_sel),
      .hit       (hit),
      .overlap   (overlap),
      .offset    (offset)
   );

   a_r9_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_sel));

   a_r9_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_sel != '0) |-> (((cs_sel - 1'b1) & match_vec) == '0));

   a_r10_overlap_has_hit: assert property (@(posedge clk) disable iff (!rst_n)
      overlap |-> (hit && $countones(match_vec) >= 2));

   a_r11_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (cs_sel == '0 && offset == '0 && !overlap));

endmodule

// File: tb/csw_decoder_test.sv
`timescale 1ns/1ps
module csw_decoder_test;

   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        allow_full;
   logic        reg_we;
   logic [9:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic [31:0] addr;
   logic [7:0]  cs_sel;
   logic        hit;
   logic        overlap;
   logic [27:0] offset;

   int vecs = 0;
   int errs = 0;
   logic [31:0] mdl [N];

   always #2.5 clk = ~clk;

   csw_decoder uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .allow_full (allow_full),
      .reg_we     (reg_we),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .addr       (addr),
      .cs_sel     (cs_sel),
      .hit        (hit),
      .overlap    (overlap),
      .offset     (offset)
   );

   function automatic logic [9:0] cfg_at(int i);
      return 10'(32'h78 + i * 32'h30);
   endfunction

   function automatic bit legal(logic [3:0] m, bit a);
      return (m == 4'h8 || m == 4'hC || m == 4'hE || m == 4'hF || (m == 4'h0 && a));
   endfunction

   // Expected {cs_sel, hit, overlap, offset}
   function automatic logic [37:0] expect_dec(logic [31:0] a, bit allow);
      logic [7:0]  cs;
      logic [27:0] ofs;
      int          n;
      cs = '0; ofs = '0; n = 0;
      for (int i = N - 1; i >= 0; i--) begin
         logic [3:0] m;
         logic [5:0] b;
         m = mdl[i][11:8];
         b = mdl[i][5:0];
         if (mdl[i][6] && legal(m, allow) && a[29:28] == b[5:4]
             && (((a[27:24] ^ b[3:0]) & m) == 4'h0)) begin
            cs  = 8'(1 << i);
            ofs = {a[27:24] & ~m, a[23:0]};
            n++;
         end
      end
      return {cs, (n > 0), (n > 1), ofs};
   endfunction

   function automatic logic [31:0] expect_rd(logic [9:0] ra);
      for (int i = 0; i < N; i++) if (ra == cfg_at(i)) return mdl[i];
      return 32'h0;
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [9:0] ra, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = ra; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      for (int i = 0; i < N; i++) if (ra == cfg_at(i)) mdl[i] = d & 32'h0000_0F7F;
   endtask

   task automatic rd(logic [9:0] ra, string req);
      @(negedge clk);
      reg_addr = ra;
      #1;
      check(req, 64'(reg_rdata), 64'(expect_rd(ra)));
   endtask

   task automatic dec(logic [31:0] a, string req);
      @(negedge clk);
      addr = a;
      #1;
      check(req, 64'({cs_sel, hit, overlap, offset}), 64'(expect_dec(a, allow_full)));
   endtask

   initial begin
      #(5.0 * 150000);
      errs++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      void'($urandom(32'h0C5D_0E1A));
      rst_n = 1'b0; allow_full = 1'b0; reg_we = 1'b0;
      reg_addr = '0; reg_wdata = '0; addr = '0;
      for (int i = 0; i < N; i++) mdl[i] = (i == 0) ? 32'hF40 : 32'hF00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R3: reset words at their bank addresses
      for (int i = 0; i < N; i++) rd(cfg_at(i), "R1 reset word");
      check("R1 region0 word", 64'(mdl[0]), 64'h0F40);
      dec(32'h0012_3456, "R7 R8 reset region0 hit");
      dec(32'h0100_0000, "R11 reset miss");
      dec(32'hC012_3456, "R7 top bits ignored");

      // R2: write masking and stray writes
      wr(cfg_at(1), 32'hFFFF_FFFF);
      rd(cfg_at(1), "R2 kept bits 0xF7F");
      dec(32'h3F00_0010, "R7 region1 full base");
      wr(10'h07C, 32'hFFFF_FFFF);
      for (int i = 0; i < N; i++) rd(cfg_at(i), "R2 stray write no effect");
      rd(10'h07C, "R3 non-config reads zero");
      rd(10'h060, "R3 non-config reads zero");

      // R5: illegal mask, then legal 64 MB window with wrap
      wr(cfg_at(2), 32'h0000_0A50);
      dec(32'h1000_0000, "R5 illegal mask disables");
      wr(cfg_at(2), 32'h0000_0C50);
      dec(32'h1300_1234, "R8 offset wraps in 64MB");

      // R6: all-zero mask needs the strap
      wr(cfg_at(3), 32'h0000_0060);
      dec(32'h2ABC_DEF0, "R6 zero mask without strap");
      allow_full = 1'b1;
      dec(32'h2ABC_DEF0, "R6 zero mask with strap");
      allow_full = 1'b0;

      // R9 / R10: overlap, lowest index wins
      wr(cfg_at(4), 32'h0000_0F40);
      dec(32'h0000_0100, "R9 R10 overlap priority");
      // R4: disable region 0
      wr(cfg_at(0), 32'h0000_0F00);
      dec(32'h0000_0100, "R4 disabled region silent");

      // Random phase
      for (int it = 0; it < 600; it++) begin
         int r;
         r = int'($urandom_range(0, 9));
         if (r < 2) begin
            logic [31:0] w;
            w = $urandom;
            w[6] = ($urandom_range(0, 3) != 0);
            wr(cfg_at(int'($urandom_range(0, N - 1))), w);
         end else if (r == 2) begin
            allow_full = 1'($urandom_range(0, 1));
            rd(cfg_at(int'($urandom_range(0, N - 1))), "R2 random readback");
         end else if (r == 3) begin
            dec($urandom, "R11 random address");
         end else begin
            int         j;
            logic [31:0] a;
            j = int'($urandom_range(0, N - 1));
            a = $urandom;
            a[29:24] = mdl[j][5:0] ^ {2'b00, 4'($urandom) & ~mdl[j][11:8]};
            dec(a, "R7 R8 R9 R10 steered address");
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

endmodule